// File: doc/BRIEF.md
# Staged Power Switch Sequencer

This block controls the eight-bit clamp code of the power switch that feeds a single processor core. A switch-on request releases the clamp in six steps. Each step holds its code for a fixed number of microsecond ticks, which limits the inrush current into the core's supply. A switch-off request forces the clamp fully closed in one write and then waits a fixed dwell. After the last step of either sequence, the block compares a readback of the clamp code against the target value. It finishes only when the two agree, or when a settle timeout expires.

A request is a single-cycle strobe. A direction bit with it selects on or off. Dwell counters advance only on the microsecond tick strobe, so the clock frequency does not affect the ramp timing. A request that asks for the state the code already holds finishes at once, with no sequence. A request that arrives while a sequence is running is dropped.

Top module: `pwr_clamp_sequencer`

## Requirements
- R1: During and right after reset, the clamp code is 0xFF (switch fully off), busy is low, done is low and the error flag is low.
- R2: A switch-on request (direction bit 1), accepted when the code is not 0x00, drives the code through 0xFE, 0xF8, 0xE0, 0xC0, 0x80 and 0x00 in that order. The first code appears in the cycle after the request.
- R3: The dwell on each switch-on code is counted in tick pulses only. It is 20 ticks on the first code, 20 on the last (0x00) and 10 on each of the four codes in between. A tick seen in the same cycle as the code write does not count.
- R4: A switch-off request (direction bit 0), accepted when the code is not 0xFF, writes 0xFF in the cycle after the request and then waits 30 ticks.
- R5: A request whose target the code already holds (0x00 for on, 0xFF for off) gives a done pulse in the next cycle. The code does not change and busy stays low.
- R6: Busy rises only in the cycle after an accepted request and stays high until done pulses. Done is one cycle wide, and busy is low whenever done is high.
- R7: A request that arrives while busy has no effect on the code sequence, the dwell timing or the result.
- R8: After the final dwell, the block samples the readback input each cycle. Done pulses in the cycle after the readback equals the target code.
- R9: If the readback has not matched after SETTLE_LIMIT cycles, the error flag sets together with a done pulse. The flag then holds until the next accepted request clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_stb | input | 1 | Single-cycle request strobe |
| req_on | input | 1 | Direction of the request: 1 switch on, 0 switch off |
| us_tick | input | 1 | One-cycle strobe once per microsecond |
| code_fb | input | 8 | Readback of the applied clamp code |
| clamp_code | output | 8 | Clamp control code (0xFF off, 0x00 on) |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle completion pulse |
| settle_err | output | 1 | The settle timeout expired on the last sequence |

## Verification
The bench runs a cycle-level reference model against the outputs. Tick spacing is irregular, so a design that counted clock cycles instead of ticks, or that counted the tick from the write cycle, would end each dwell early or late. Random requests land in the middle of ramps and settle phases; a design that accepted them would restart or reverse the ladder. Repeated requests for the state already held catch a design that ramps needlessly or raises busy. A stuck readback forces the timeout path, which catches a design that hangs, never raises the error flag, or fails to clear the flag on the next request.

// File: rtl/pwr_clamp_pkg.sv
// Package: shared constants, state type and the switch-on code ladder.
// Assumes an eight-bit clamp code, all-ones meaning the switch is fully off.
package pwr_clamp_pkg;

    localparam int          CODE_W   = 8;
    localparam int          STEPS    = 6;
    localparam int          STEP_W   = $clog2(STEPS);
    localparam logic [7:0]  CODE_OFF = 8'hFF;
    localparam logic [7:0]  CODE_ON  = 8'h00;

    typedef enum logic [1:0] {
        SQ_IDLE   = 2'd0,
        SQ_RAMP   = 2'd1,
        SQ_DROP   = 2'd2,
        SQ_SETTLE = 2'd3
    } seq_state_t;

    // Clamp code applied at switch-on step idx (clamp segments released progressively).
    function automatic logic [7:0] ramp_code(input int idx);
        logic [7:0] c;
        case (idx)
            0:       c = 8'hFE;
            1:       c = 8'hF8;
            2:       c = 8'hE0;
            3:       c = 8'hC0;
            4:       c = 8'h80;
            default: c = 8'h00;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/pwr_ladder_table.sv
// Module: step table for the switch-on ladder.
// Returns the clamp code and dwell length (in ticks) for a step index.
// The first and last steps use the long dwell, the ones between use the short dwell.
// Assumes step_idx stays below STEPS; larger values read as the last step.
module pwr_ladder_table
    import pwr_clamp_pkg::*;
#(
    parameter int DWELL_LONG  = 20,
    parameter int DWELL_SHORT = 10,
    parameter int CNT_W       = 5
) (
    input  logic [STEP_W-1:0] step_idx,
    output logic [7:0]        step_code,
    output logic [CNT_W-1:0]  step_dwell
);

    logic [7:0]       code_arr  [STEPS];
    logic [CNT_W-1:0] dwell_arr [STEPS];

    // Build one table entry per ladder step.
    for (genvar g = 0; g < STEPS; g++) begin : g_step
        localparam int DW = ((g == 0) || (g == STEPS - 1)) ? DWELL_LONG : DWELL_SHORT;
        assign code_arr[g]  = ramp_code(g);
        assign dwell_arr[g] = CNT_W'(DW);
    end

    // Select the entry for the current step, clamping out-of-range indices.
    always_comb begin
        if (int'(step_idx) < STEPS) begin
            step_code  = code_arr[step_idx];
            step_dwell = dwell_arr[step_idx];
        end else begin
            step_code  = code_arr[STEPS-1];
            step_dwell = dwell_arr[STEPS-1];
        end
    end

endmodule

// File: rtl/pwr_tick_dwell.sv
// Module: dwell counter driven by the microsecond tick.
// Counts tick pulses while run is high. expire goes high, without a register,
// in the cycle that carries the limit-th tick; the count then restarts from zero.
// Assumes limit >= 1 and that limit is held steady while run is high.
module pwr_tick_dwell #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic [CNT_W-1:0] limit,
    output logic             expire
);

    logic [CNT_W-1:0] cnt_q;

    // Flag the last tick of the current dwell.
    assign expire = run && tick && (cnt_q == limit - CNT_W'(1));

    // Count ticks while running; clear when idle or when a dwell ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || expire) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

endmodule

// File: rtl/pwr_settle_guard.sv
// Module: readback watchdog for the settle phase.
// While active, counts cycles in which the readback disagrees with the target.
// timeout goes high, without a register, on the LIMIT-th cycle with no match.
// Assumes LIMIT >= 1.
module pwr_settle_guard #(
    parameter int LIMIT = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic match,
    output logic timeout
);

    localparam int TW = $clog2(LIMIT + 1);

    logic [TW-1:0] wait_q;

    // Raise timeout on the last permitted mismatch cycle.
    assign timeout = active && !match && (wait_q == TW'(LIMIT - 1));

    // Count mismatch cycles only while the settle phase is active.
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            wait_q <= '0;
        end else if (!match && !timeout) begin
            wait_q <= wait_q + TW'(1);
        end
    end

endmodule

// File: rtl/pwr_clamp_sequencer.sv
// Module: staged power switch sequencer (top).
// Sequences one core's clamp code: a six-step ramp to switch on, a single jump
// to switch off, then a readback settle check guarded by a timeout.
// Assumes req_stb and us_tick are single-cycle strobes synchronous to clk,
// and that code_fb reflects clamp_code through whatever path applies it.
module pwr_clamp_sequencer
    import pwr_clamp_pkg::*;
#(
    parameter int DWELL_LONG   = 20,
    parameter int DWELL_SHORT  = 10,
    parameter int DWELL_OFF    = 30,
    parameter int SETTLE_LIMIT = 256
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_stb,
    input  logic       req_on,
    input  logic       us_tick,
    input  logic [7:0] code_fb,
    output logic [7:0] clamp_code,
    output logic       busy,
    output logic       done,
    output logic       settle_err
);

    localparam int MAX_DW = (DWELL_OFF > DWELL_LONG)
                          ? ((DWELL_OFF > DWELL_SHORT) ? DWELL_OFF : DWELL_SHORT)
                          : ((DWELL_LONG > DWELL_SHORT) ? DWELL_LONG : DWELL_SHORT);
    localparam int CNT_W  = $clog2(MAX_DW + 1);
    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(STEPS - 1);

    seq_state_t        state_q;
    logic [STEP_W-1:0] step_q;
    logic [7:0]        code_q;
    logic              busy_q;
    logic              done_q;
    logic              err_q;
    logic              tgt_on_q;

    logic [7:0]        tbl_code;
    logic [CNT_W-1:0]  tbl_dwell;
    logic [7:0]        next_code;
    logic [CNT_W-1:0]  tbl_unused_dwell;
    logic [CNT_W-1:0]  dwell_limit;
    logic              dwell_run;
    logic              dwell_end;
    logic              settle_active;
    logic              fb_match;
    logic              settle_to;
    logic              at_target;
    logic [STEP_W-1:0] step_next;

    // Table lookup for the code and dwell of the current step.
    pwr_ladder_table #(
        .DWELL_LONG  (DWELL_LONG),
        .DWELL_SHORT (DWELL_SHORT),
        .CNT_W       (CNT_W)
    ) u_table (
        .step_idx   (step_q),
        .step_code  (tbl_code),
        .step_dwell (tbl_dwell)
    );

    // Second lookup giving the code of the step that comes next.
    pwr_ladder_table #(
        .DWELL_LONG  (DWELL_LONG),
        .DWELL_SHORT (DWELL_SHORT),
        .CNT_W       (CNT_W)
    ) u_table_next (
        .step_idx   (step_next),
        .step_code  (next_code),
        .step_dwell (tbl_unused_dwell)
    );

    // Index of the following step, saturating at the last step.
    assign step_next = (step_q == LAST_STEP) ? LAST_STEP : step_q + STEP_W'(1);

    // Pick the dwell: the switch-off wait in the drop phase, the table value on the ramp.
    always_comb begin
        dwell_limit = (state_q == SQ_DROP) ? CNT_W'(DWELL_OFF) : tbl_dwell;
        dwell_run   = (state_q == SQ_RAMP) || (state_q == SQ_DROP);
    end

    // Tick-based dwell counter shared by the ramp and drop phases.
    pwr_tick_dwell #(
        .CNT_W (CNT_W)
    ) u_dwell (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (dwell_run),
        .tick   (us_tick),
        .limit  (dwell_limit),
        .expire (dwell_end)
    );

    // Compare the readback with the target of the current sequence.
    always_comb begin
        settle_active = (state_q == SQ_SETTLE);
        fb_match      = (code_fb == (tgt_on_q ? CODE_ON : CODE_OFF));
    end

    // Settle watchdog, so that a readback that never matches cannot hang the block.
    pwr_settle_guard #(
        .LIMIT (SETTLE_LIMIT)
    ) u_guard (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (settle_active),
        .match   (fb_match),
        .timeout (settle_to)
    );

    // Detect a request for the state the code already holds.
    assign at_target = req_on ? (code_q == CODE_ON) : (code_q == CODE_OFF);

    // Main sequencing state machine and output registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= SQ_IDLE;
            step_q   <= '0;
            code_q   <= CODE_OFF;
            busy_q   <= 1'b0;
            done_q   <= 1'b0;
            err_q    <= 1'b0;
            tgt_on_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                SQ_IDLE: begin
                    if (req_stb) begin
                        err_q <= 1'b0;
                        if (at_target) begin
                            done_q <= 1'b1;
                        end else if (req_on) begin
                            tgt_on_q <= 1'b1;
                            step_q   <= '0;
                            code_q   <= ramp_code(0);
                            busy_q   <= 1'b1;
                            state_q  <= SQ_RAMP;
                        end else begin
                            tgt_on_q <= 1'b0;
                            code_q   <= CODE_OFF;
                            busy_q   <= 1'b1;
                            state_q  <= SQ_DROP;
                        end
                    end
                end
                SQ_RAMP: begin
                    if (dwell_end) begin
                        if (step_q == LAST_STEP) begin
                            state_q <= SQ_SETTLE;
                        end else begin
                            step_q <= step_next;
                            code_q <= next_code;
                        end
                    end
                end
                SQ_DROP: begin
                    if (dwell_end) begin
                        state_q <= SQ_SETTLE;
                    end
                end
                SQ_SETTLE: begin
                    if (fb_match || settle_to) begin
                        err_q   <= settle_to;
                        done_q  <= 1'b1;
                        busy_q  <= 1'b0;
                        state_q <= SQ_IDLE;
                    end
                end
                default: state_q <= SQ_IDLE;
            endcase
        end
    end

    // Drive the outputs straight from registers.
    always_comb begin
        clamp_code = code_q;
        busy       = busy_q;
        done       = done_q;
        settle_err = err_q;
    end

    // The current-step code from the table is used only by the checker; keep it visible.
    logic tbl_seen;
    assign tbl_seen = ^{tbl_code, tbl_unused_dwell};

endmodule

// File: rtl/pwr_clamp_checker.sv
// Module: assertion checker for the sequencer, attached with bind.
// Watches the ports together with the internal state and the current table code.
module pwr_clamp_checker
    import pwr_clamp_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       req_stb,
    input logic [7:0] clamp_code,
    input logic [7:0] tbl_code,
    input logic       busy,
    input logic       done,
    input logic       settle_err,
    input logic       tbl_seen,
    input seq_state_t state_q
);

    // Expected successor of a code on the switch-on ladder.
    function automatic logic [7:0] ladder_next(input logic [7:0] c);
        logic [7:0] n;
        case (c)
            8'hFF:   n = 8'hFE;
            8'hFE:   n = 8'hF8;
            8'hF8:   n = 8'hE0;
            8'hE0:   n = 8'hC0;
            8'hC0:   n = 8'h80;
            default: n = 8'h00;
        endcase
        return n;
    endfunction

    // R1: reset forces the switch off and the block idle.
    assert_reset_off_R1: assert property (@(posedge clk)
        !rst_n |=> (clamp_code == 8'hFF && !busy && !done && !settle_err));

    // R2: any code change is either a full-off jump or the next ladder step.
    assert_ladder_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (clamp_code != $past(clamp_code)) |->
            (clamp_code == 8'hFF || clamp_code == ladder_next($past(clamp_code))));

    // R2: while ramping, the applied code matches the table entry for the step.
    assert_ramp_table_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SQ_RAMP) |-> (clamp_code == tbl_code));

    // R4: throughout the switch-off wait the clamp is fully closed.
    assert_drop_closed_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SQ_DROP) |-> (clamp_code == 8'hFF));

    // R6: busy and done are never high together.
    assert_done_not_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R6: busy starts only in the cycle after a request.
    assert_busy_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(req_stb));

    // R6: busy falls only together with a done pulse.
    assert_busy_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R7: the code stays frozen while waiting for the readback to settle.
    assert_settle_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SQ_SETTLE && $past(state_q) == SQ_SETTLE) |-> $stable(clamp_code));

    // R9: the error flag rises only with a done pulse.
    assert_err_with_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(settle_err) |-> done);

    // The table parity tap is a plain combinational value; it must never be unknown.
    assert_tbl_known_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$isunknown(tbl_seen));

endmodule

bind pwr_clamp_sequencer pwr_clamp_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_stb    (req_stb),
    .clamp_code (clamp_code),
    .tbl_code   (tbl_code),
    .busy       (busy),
    .done       (done),
    .settle_err (settle_err),
    .tbl_seen   (tbl_seen),
    .state_q    (state_q)
);

// File: tb/sim_pwr_clamp_sequencer.sv
// Bench: random and directed stimulus, checked every cycle against a reference model.
module sim_pwr_clamp_sequencer;

    localparam int LIMIT = 40;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_stb = 1'b0;
    logic       req_on = 1'b0;
    logic       us_tick = 1'b0;
    logic       fb_stuck = 1'b0;
    logic [7:0] code_fb;
    logic [7:0] clamp_code;
    logic       busy, done, settle_err;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int tick_pct = 40;
    int req_pct = 2;
    bit model_on = 1'b0;

    always #4 clk = ~clk;

    assign code_fb = fb_stuck ? 8'h5A : clamp_code;

    pwr_clamp_sequencer #(.SETTLE_LIMIT(LIMIT)) u0 (
        .clk(clk), .rst_n(rst_n), .req_stb(req_stb), .req_on(req_on),
        .us_tick(us_tick), .code_fb(code_fb), .clamp_code(clamp_code),
        .busy(busy), .done(done), .settle_err(settle_err)
    );

    // Reference model state.
    int         m_st = 0;   // 0 idle, 1 ramp, 2 drop, 3 settle
    int         m_step, m_cnt, m_tmr;
    logic [7:0] m_code = 8'hFF;
    bit         m_busy, m_done, m_err, m_tgt;

    function automatic logic [7:0] exp_code(input int i);
        case (i)
            0: return 8'hFE; 1: return 8'hF8; 2: return 8'hE0;
            3: return 8'hC0; 4: return 8'h80; default: return 8'h00;
        endcase
    endfunction

    function automatic int exp_dwell(input int i);
        return (i == 0 || i == 5) ? 20 : 10;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s cycle %0d: actual=%0h expected=%0h", tag, cyc, act, exp);
        end
    endtask

    // Advance the model by one clock edge and compare it with the outputs.
    always @(posedge clk) begin
        #2;
        cyc++;
        if (model_on) begin
            string tag;
            logic [7:0] fbv;
            fbv = fb_stuck ? 8'h5A : m_code;
            tag = (m_st == 1) ? "R3" : (m_st == 2) ? "R4" : (m_st == 3) ? "R8" : "R5";
            if (m_st != 0 && req_stb) tag = "R7";
            m_done = 1'b0;
            case (m_st)
                0: if (req_stb) begin
                    m_err = 1'b0;
                    if ((req_on && m_code == 8'h00) || (!req_on && m_code == 8'hFF)) begin
                        m_done = 1'b1;
                    end else if (req_on) begin
                        m_tgt = 1'b1; m_step = 0; m_cnt = 0; m_code = exp_code(0);
                        m_busy = 1'b1; m_st = 1; tag = "R2";
                    end else begin
                        m_tgt = 1'b0; m_cnt = 0; m_code = 8'hFF; m_busy = 1'b1; m_st = 2;
                        tag = "R4";
                    end
                end
                1: if (us_tick) begin
                    if (m_cnt == exp_dwell(m_step) - 1) begin
                        m_cnt = 0;
                        if (m_step == 5) begin m_st = 3; m_tmr = 0; end
                        else begin m_step++; m_code = exp_code(m_step); tag = "R2"; end
                    end else m_cnt++;
                end
                2: if (us_tick) begin
                    if (m_cnt == 29) begin m_st = 3; m_tmr = 0; m_cnt = 0; end
                    else m_cnt++;
                end
                default: begin
                    if (fbv == (m_tgt ? 8'h00 : 8'hFF)) begin
                        m_done = 1'b1; m_busy = 1'b0; m_st = 0;
                    end else if (m_tmr == LIMIT - 1) begin
                        m_err = 1'b1; m_done = 1'b1; m_busy = 1'b0; m_st = 0; tag = "R9";
                    end else m_tmr++;
                end
            endcase
            check(clamp_code == m_code, tag, clamp_code, m_code);
            check(busy == m_busy, "R6", busy, m_busy);
            check(done == m_done, tag, done, m_done);
            check(settle_err == m_err, "R9", settle_err, m_err);
        end
    end

    // Tick and random-request driver on the falling edge.
    always @(negedge clk) begin
        us_tick <= ($urandom_range(0, 99) < tick_pct);
    end

    task automatic pulse_req(input bit on);
        @(negedge clk);
        req_stb = 1'b1; req_on = on;
        @(negedge clk);
        req_stb = 1'b0;
    endtask

    task automatic wait_idle();
        while (m_st != 0 || m_done) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic random_run(input int n, input int pct);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            req_stb = ($urandom_range(0, 99) < pct);
            req_on  = $urandom_range(0, 1);
        end
        @(negedge clk);
        req_stb = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(1234));
        repeat (4) @(negedge clk);
        // R1: outputs during reset.
        check(clamp_code == 8'hFF, "R1", clamp_code, 8'hFF);
        check(!busy && !done && !settle_err, "R1", {busy, done, settle_err}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(clamp_code == 8'hFF && !busy, "R1", clamp_code, 8'hFF);
        model_on = 1'b1;

        // R5: switch-off while already off completes at once.
        pulse_req(1'b0);
        check(done == 1'b1 && busy == 1'b0, "R5", {done, busy}, 2'b10);
        check(clamp_code == 8'hFF, "R5", clamp_code, 8'hFF);

        // R2/R3: full ramp with requests thrown in mid-sequence (R7).
        pulse_req(1'b1);
        check(clamp_code == 8'hFE && busy, "R2", clamp_code, 8'hFE);
        repeat (30) @(negedge clk);
        pulse_req(1'b0);
        wait_idle();
        check(clamp_code == 8'h00, "R8", clamp_code, 8'h00);

        // R5: switch-on while already on.
        pulse_req(1'b1);
        check(done == 1'b1 && busy == 1'b0 && clamp_code == 8'h00, "R5", clamp_code, 8'h00);

        // R4: switch-off from on, with a stray request while busy (R7).
        pulse_req(1'b0);
        check(clamp_code == 8'hFF && busy, "R4", clamp_code, 8'hFF);
        repeat (5) @(negedge clk);
        pulse_req(1'b1);
        wait_idle();

        // R9: stuck readback forces the timeout.
        fb_stuck = 1'b1;
        pulse_req(1'b1);
        wait_idle();
        check(settle_err == 1'b1, "R9", settle_err, 1);
        fb_stuck = 1'b0;
        pulse_req(1'b0);
        check(settle_err == 1'b0, "R9", settle_err, 0);
        wait_idle();

        // Dense and sparse ticks with random requests.
        tick_pct = 100;
        random_run(2000, 3);
        tick_pct = 15;
        random_run(4000, 1);
        wait_idle();

        // Random stuck-readback phases.
        for (int k = 0; k < 4; k++) begin
            fb_stuck = $urandom_range(0, 1);
            tick_pct = $urandom_range(20, 90);
            random_run(1500, 2);
            wait_idle();
        end
        fb_stuck = 1'b0;
        repeat (4) @(negedge clk);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule